// File: doc/BRIEF.md
# CAN Message-Buffer Interrupt Gatherer

This block collects the interrupt-worthy events of a CAN controller's message buffers and its error detector into one pending register, masks that register with a software-programmed enable register and drives a single interrupt request line shared by all sources. Each message buffer reports four kinds of event: a data frame received into a buffer that was ready, a data frame sent from a one-shot transmit request, a data reply sent in answer to a remote request, and a transmit being scheduled because a remote request arrived. Any of them sets that buffer's pending bit. One extra pending bit, above the buffer bits, records a detected bus error. Each error event ORs its diagnostic code into a sticky diagnostic field.

Software sees the pending flags only as a read-only vector. It removes flags by writing ones to a separate clear port and programs the enable register as a whole. Pending flags are recorded whether or not they are enabled, so software can poll masked sources. A separate wake-up pulse fires on any data-frame reception. It does not depend on the enables or the pending state, so a sleeping system can be woken without taking the interrupt path.

Top module: `can_irq_gather`

## Requirements
- R1: After reset the pending vector, the enable vector and the diagnostic field are all zero, and `irq_o` and `wake_o` are low.
- R2: A pulse on any of `rx_ev`, `tx_ev`, `rsp_ev` or `sched_ev` at bit i sets pending bit i at the next clock edge, whatever the value of enable bit i.
- R3: A pulse on `err_ev` sets pending bit NBUF (the top bit) at the next edge and ORs `err_code` into `diag_q`.
- R4: When `clr_wr` is high, each one in `clr_mask` clears the matching pending bit at the next edge, and each zero leaves its bit unchanged. With no set event and no clear, a pending bit holds its value.
- R5: If a set event and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R6: `irq_o` is high exactly when some bit index i in 0..NBUF has both pending bit i and enable bit i set. Enable bit NBUF gates the error bit.
- R7: When `en_wr` is high, `en_q` takes `en_wdata` at the next edge. Otherwise it holds its value.
- R8: `wake_o` is high for the cycle after any cycle in which some `rx_ev` bit is high, and low otherwise, independent of enables and pending flags.
- R9: A clear of pending bit NBUF with no error event in that cycle zeroes `diag_q`. With an error event in that same cycle, `diag_q` takes the new `err_code` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_ev | input | NBUF | Per-buffer data-frame reception event |
| tx_ev | input | NBUF | Per-buffer one-shot data transmission done |
| rsp_ev | input | NBUF | Per-buffer remote reply transmitted |
| sched_ev | input | NBUF | Per-buffer transmit scheduled by a remote request |
| err_ev | input | 1 | Bus error detected |
| err_code | input | DIAG_W | Diagnostic code of the error event |
| clr_wr | input | 1 | Clear-register write strobe |
| clr_mask | input | NBUF+1 | Ones clear pending bits; bit NBUF is the error bit |
| en_wr | input | 1 | Enable-register write strobe |
| en_wdata | input | NBUF+1 | New enable vector; bit NBUF enables the error bit |
| pend_q | output | NBUF+1 | Read-only pending flags |
| en_q | output | NBUF+1 | Enable register read-back |
| diag_q | output | DIAG_W | Sticky diagnostic code |
| irq_o | output | 1 | Shared interrupt request |
| wake_o | output | 1 | Wake-up pulse on data-frame reception |

## Verification
The bench builds the block with NBUF = 6 and DIAG_W = 3. With that width every pending bit, including the error bit at index 6, can be driven and checked with short literal masks. The narrow diagnostic field makes the OR accumulation of two different codes reach the all-ones value in two error events. The small vector also lets the set-wins collision, the all-zero clear and the enable-gated error path each be shown on an exactly known pending value.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  // One pending flag's next value: a set event outranks a clear request.
  function automatic logic pend_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // One source's contribution to the shared interrupt line.
  function automatic logic src_active(input logic pend, input logic en);
    return pend & en;
  endfunction

  // Next diagnostic field: accumulate, or restart when the error flag is cleared.
  function automatic logic [31:0] diag_next(input logic [31:0] cur, input logic [31:0] code,
                                            input logic ev, input logic clr);
    logic [31:0] base;
    base = clr ? 32'd0 : cur;
    return ev ? (base | code) : base;
  endfunction

endpackage

// File: rtl/can_irq_evt_merge.sv
module can_irq_evt_merge #(
  parameter int NBUF = 16
) (
  input  logic [NBUF-1:0] rx_ev,
  input  logic [NBUF-1:0] tx_ev,
  input  logic [NBUF-1:0] rsp_ev,
  input  logic [NBUF-1:0] sched_ev,
  output logic [NBUF-1:0] buf_set,
  output logic            rx_any
);
  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    assign buf_set[i] = rx_ev[i] | tx_ev[i] | rsp_ev[i] | sched_ev[i];
  end
  assign rx_any = |rx_ev;
endmodule

// File: rtl/can_irq_pend_reg.sv
module can_irq_pend_reg
  import can_irq_pkg::*;
#(
  parameter int NBITS = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set_vec,
  input  logic             clr_wr,
  input  logic [NBITS-1:0] clr_mask,
  output logic [NBITS-1:0] pend_q
);
  logic [NBITS-1:0] clr_hit;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    assign clr_hit[i] = clr_wr & clr_mask[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_next(pend_q[i], set_vec[i], clr_hit[i]);
    end

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> pend_q[i]);
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[i] && !set_vec[i]) |=> !pend_q[i]);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_hit[i] && !set_vec[i]) |=> $stable(pend_q[i]));
  end
endmodule

// File: rtl/can_irq_err_latch.sv
module can_irq_err_latch
  import can_irq_pkg::*;
#(
  parameter int DIAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_ev,
  input  logic [DIAG_W-1:0] err_code,
  input  logic              err_clr,
  output logic [DIAG_W-1:0] diag_q
);
  logic [31:0] nxt;

  always_comb begin
    nxt = diag_next(32'(diag_q), 32'(err_code), err_ev, err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) diag_q <= '0;
    else        diag_q <= nxt[DIAG_W-1:0];
  end

  assert_diag_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !err_ev) |=> (diag_q == '0));
  assert_diag_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ev && !err_clr) |=> ((diag_q & $past(err_code)) == $past(err_code)));
endmodule

// File: rtl/can_irq_mask.sv
module can_irq_mask
  import can_irq_pkg::*;
#(
  parameter int NBITS = 17
) (
  input  logic [NBITS-1:0] pend,
  input  logic [NBITS-1:0] en,
  output logic             irq
);
  logic [NBITS-1:0] active;
  for (genvar i = 0; i < NBITS; i++) begin : g_src
    assign active[i] = src_active(pend[i], en[i]);
  end
  assign irq = |active;
endmodule

// File: rtl/can_irq_gather.sv
module can_irq_gather #(
  parameter int NBUF   = 16,
  parameter int DIAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBUF-1:0]   rx_ev,
  input  logic [NBUF-1:0]   tx_ev,
  input  logic [NBUF-1:0]   rsp_ev,
  input  logic [NBUF-1:0]   sched_ev,
  input  logic              err_ev,
  input  logic [DIAG_W-1:0] err_code,
  input  logic              clr_wr,
  input  logic [NBUF:0]     clr_mask,
  input  logic              en_wr,
  input  logic [NBUF:0]     en_wdata,
  output logic [NBUF:0]     pend_q,
  output logic [NBUF:0]     en_q,
  output logic [DIAG_W-1:0] diag_q,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int NBITS = NBUF + 1;
  localparam int ERR_BIT = NBUF;

  logic [NBUF-1:0]  buf_set;
  logic             rx_any;
  logic [NBITS-1:0] set_vec;
  logic             err_clr;

  can_irq_evt_merge #(.NBUF(NBUF)) u_merge (
    .rx_ev(rx_ev), .tx_ev(tx_ev), .rsp_ev(rsp_ev), .sched_ev(sched_ev),
    .buf_set(buf_set), .rx_any(rx_any)
  );

  assign set_vec = {err_ev, buf_set};
  assign err_clr = clr_wr & clr_mask[ERR_BIT];

  can_irq_pend_reg #(.NBITS(NBITS)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .pend_q(pend_q)
  );

  can_irq_err_latch #(.DIAG_W(DIAG_W)) u_diag (
    .clk(clk), .rst_n(rst_n), .err_ev(err_ev), .err_code(err_code),
    .err_clr(err_clr), .diag_q(diag_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_o <= 1'b0;
    else        wake_o <= rx_any;
  end

  can_irq_mask #(.NBITS(NBITS)) u_mask (
    .pend(pend_q), .en(en_q), .irq(irq_o)
  );

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_ev) |=> wake_o);
  assert_wake_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|rx_ev) |=> !wake_o);
  assert_enable_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_q == $past(en_wdata)));
  assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q));
  assert_err_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_ev |=> pend_q[ERR_BIT]);
  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & en_q) == '0) |-> !irq_o);
endmodule

// File: tb/can_irq_gather_tb_top.sv
`timescale 1ns/1ps
module can_irq_gather_tb_top;
  localparam int NB = 6;
  localparam int DW = 3;

  typedef struct packed {
    logic [NB-1:0] rx, tx, rsp, sch;
    logic          err;
    logic [DW-1:0] code;
    logic          cw;
    logic [NB:0]   clr;
    logic          ew;
    logic [NB:0]   en;
    logic [NB:0]   x_pend;
    logic [DW-1:0] x_diag;
    logic          x_irq;
    logic          x_wake;
  } vec_t;

  // rx tx rsp sch err code cw clr ew en | pend diag irq wake
  localparam vec_t VEC [13] = '{
    '{6'h01,6'h00,6'h00,6'h00,1'b0,3'd0,1'b0,7'h00,1'b0,7'h00, 7'h01,3'd0,1'b0,1'b1}, // R2 R8 masked
    '{6'h00,6'h04,6'h00,6'h00,1'b0,3'd0,1'b0,7'h00,1'b0,7'h00, 7'h05,3'd0,1'b0,1'b0}, // R2 tx
    '{6'h00,6'h00,6'h00,6'h00,1'b0,3'd0,1'b0,7'h00,1'b1,7'h04, 7'h05,3'd0,1'b1,1'b0}, // R6 R7
    '{6'h00,6'h00,6'h08,6'h10,1'b0,3'd0,1'b0,7'h00,1'b0,7'h00, 7'h1D,3'd0,1'b1,1'b0}, // R2 rsp sched
    '{6'h00,6'h00,6'h00,6'h00,1'b0,3'd0,1'b1,7'h04,1'b0,7'h00, 7'h19,3'd0,1'b0,1'b0}, // R4
    '{6'h00,6'h00,6'h00,6'h00,1'b1,3'd5,1'b0,7'h00,1'b0,7'h00, 7'h59,3'd5,1'b0,1'b0}, // R3
    '{6'h00,6'h00,6'h00,6'h00,1'b0,3'd0,1'b0,7'h00,1'b1,7'h40, 7'h59,3'd5,1'b1,1'b0}, // R6 error gate
    '{6'h00,6'h00,6'h00,6'h00,1'b1,3'd2,1'b0,7'h00,1'b0,7'h00, 7'h59,3'd7,1'b1,1'b0}, // R3 accumulate
    '{6'h00,6'h00,6'h00,6'h00,1'b0,3'd0,1'b1,7'h40,1'b0,7'h00, 7'h19,3'd0,1'b0,1'b0}, // R9 clear
    '{6'h20,6'h00,6'h00,6'h00,1'b0,3'd0,1'b1,7'h21,1'b0,7'h00, 7'h38,3'd0,1'b0,1'b1}, // R5
    '{6'h00,6'h00,6'h00,6'h00,1'b0,3'd0,1'b1,7'h00,1'b0,7'h00, 7'h38,3'd0,1'b0,1'b0}, // R4 zeros
    '{6'h00,6'h00,6'h00,6'h00,1'b1,3'd3,1'b1,7'h40,1'b0,7'h00, 7'h78,3'd3,1'b1,1'b0}, // R5 R9
    '{6'h00,6'h00,6'h00,6'h02,1'b0,3'd0,1'b0,7'h00,1'b1,7'h00, 7'h7A,3'd3,1'b0,1'b0}  // R2 R6
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] rx_ev = '0, tx_ev = '0, rsp_ev = '0, sched_ev = '0;
  logic err_ev = 1'b0;
  logic [DW-1:0] err_code = '0;
  logic clr_wr = 1'b0, en_wr = 1'b0;
  logic [NB:0] clr_mask = '0, en_wdata = '0;
  logic [NB:0] pend_q, en_q;
  logic [DW-1:0] diag_q;
  logic irq_o, wake_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_irq_gather #(.NBUF(NB), .DIAG_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_ev(rx_ev), .tx_ev(tx_ev), .rsp_ev(rsp_ev),
    .sched_ev(sched_ev), .err_ev(err_ev), .err_code(err_code), .clr_wr(clr_wr),
    .clr_mask(clr_mask), .en_wr(en_wr), .en_wdata(en_wdata), .pend_q(pend_q),
    .en_q(en_q), .diag_q(diag_q), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rx_ev = '0; tx_ev = '0; rsp_ev = '0; sched_ev = '0;
    err_ev = 1'b0; err_code = '0; clr_wr = 1'b0; clr_mask = '0;
    en_wr = 1'b0; en_wdata = '0;
  endtask

  task automatic check_zero(input string req);
    check({req, " pend"}, 32'(pend_q), 32'h0);
    check({req, " en"},   32'(en_q),   32'h0);
    check({req, " diag"}, 32'(diag_q), 32'h0);
    check({req, " irq"},  32'(irq_o),  32'h0);
    check({req, " wake"}, 32'(wake_o), 32'h0);
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    check_zero("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 13; k++) begin
      rx_ev = VEC[k].rx; tx_ev = VEC[k].tx; rsp_ev = VEC[k].rsp; sched_ev = VEC[k].sch;
      err_ev = VEC[k].err; err_code = VEC[k].code;
      clr_wr = VEC[k].cw; clr_mask = VEC[k].clr;
      en_wr = VEC[k].ew; en_wdata = VEC[k].en;
      @(negedge clk);
      idle_inputs();
      check($sformatf("R2/R4/R5 pend vec %0d", k), 32'(pend_q), 32'(VEC[k].x_pend));
      check($sformatf("R3/R9 diag vec %0d", k),    32'(diag_q), 32'(VEC[k].x_diag));
      check($sformatf("R6 irq vec %0d", k),        32'(irq_o),  32'(VEC[k].x_irq));
      check($sformatf("R8 wake vec %0d", k),       32'(wake_o), 32'(VEC[k].x_wake));
    end
    // R7: enable readback and hold
    en_wr = 1'b1; en_wdata = 7'h2A;
    @(negedge clk);
    idle_inputs();
    check("R7 enable written", 32'(en_q), 32'h2A);
    check("R6 irq with en 2A on pend 7A", 32'(irq_o), 32'h1);
    en_wdata = 7'h11;
    @(negedge clk);
    check("R7 enable holds without strobe", 32'(en_q), 32'h2A);
    // R4: clearing every flag silences the line
    clr_wr = 1'b1; clr_mask = 7'h7F;
    @(negedge clk);
    idle_inputs();
    check("R4 clear all pend", 32'(pend_q), 32'h0);
    check("R6 irq low after clear", 32'(irq_o), 32'h0);
    check("R3 diag after error clear", 32'(diag_q), 32'h0);
    // R1: reset in mid-run
    sched_ev = 6'h3F; err_ev = 1'b1; err_code = 3'd6;
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    check_zero("R1 mid-run reset");
    rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule